// File: doc/BRIEF.md
# Edge-Stepped Contrast Code Counter

This block keeps a six-bit contrast code that drives an external LCD bias DAC. Two active-low push inputs, one for raising and one for lowering the code, come from outside the clock domain. Each is brought in through a two-flop synchronizer. A small state machine then turns the synchronized levels into one-shot commands. A clean falling edge on one input moves the code one count in that direction. Holding both inputs low presets the code to the middle of its range. Reset loads the same middle value, not zero.

The state machine has four states, named after the synchronized input pair: `S_REST` (both high), `S_UP_HELD` (only the raise input low), `S_DN_HELD` (only the lower input low) and `S_PRESET` (both low). The commands come from the transitions:
- `S_REST` or `S_DN_HELD` to `S_UP_HELD` issues an increment.
- `S_REST` or `S_UP_HELD` to `S_DN_HELD` issues a decrement.
- Any move into `S_PRESET`, and every cycle spent there, issues the midscale preset.
- All other transitions, including `S_PRESET` to either held state and any return to `S_REST`, issue nothing.

A step that would leave the range does not change the code and raises a one-cycle saturation flag. An active-low power-down input freezes the code while it is low. The state machine keeps following the inputs during power-down, so edges seen while frozen are dropped rather than stored.

Top module: `contrast_code_ctrl`

## Requirements
- R1: During and after reset, before any input activity, `code` is 32 (binary 100000) and `sat` is 0.
- R2: A falling edge on `step_up_n` while `step_dn_n` is high raises `code` by exactly one. The new value appears at the third rising clock edge after the input changes.
- R3: A falling edge on `step_dn_n` while `step_up_n` is high lowers `code` by exactly one, with the same three-edge latency.
- R4: Whenever both step inputs are low (synchronized), `code` is forced to 32. Releasing one of them while the other stays low causes no step.
- R5: If both step inputs fall in the same cycle, the result is the midscale preset (32) and no step is taken.
- R6: A raise edge at code 63 leaves `code` at 63 and sets `sat` high for exactly one cycle.
- R7: A lower edge at code 0 leaves `code` at 0 and sets `sat` high for exactly one cycle.
- R8: While `pwr_dn_n` is low, `code` holds its value and `sat` stays 0, whatever the step inputs do, including both low. Edges that occur during power-down are not applied after power returns.
- R9: Each falling edge produces at most one step. Holding an input low and releasing it (the rising edge) does not change `code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads midscale |
| pwr_dn_n | input | 1 | Active-low power-down, synchronous to clk; low freezes the code |
| step_up_n | input | 1 | Asynchronous active-low raise input |
| step_dn_n | input | 1 | Asynchronous active-low lower input |
| code | output | 6 | Current contrast code |
| sat | output | 1 | One-cycle pulse when a step is refused at a range limit |

## Verification
A single step and the both-low midscale preset can land in the same cycle. This happens when both inputs fall on the same clock, or when one input falls while the other is already held low. The bench sets up each case from a code far from 32. It then checks that the code lands on exactly 32 at the expected edge, not one count above or below. It also checks that releasing one input afterwards causes no late step. The full range is covered by stepping one count at a time from 32 to 63 and then down to 0, with each value and the two refused steps checked against arithmetic expectations.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
    typedef enum logic [1:0] {
        S_REST    = 2'd0,
        S_UP_HELD = 2'd1,
        S_DN_HELD = 2'd2,
        S_PRESET  = 2'd3
    } step_state_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_INC  = 2'd1,
        CMD_DEC  = 2'd2,
        CMD_MID  = 2'd3
    } step_cmd_e;
endpackage

// File: rtl/ccc_sync.sv
module ccc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ccc_step_fsm.sv
module ccc_step_fsm
    import ccc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      up_lvl_n,
    input  logic      dn_lvl_n,
    output step_cmd_e cmd_o
);
    step_state_e state_q, state_d;

    always_comb begin
        unique case ({up_lvl_n, dn_lvl_n})
            2'b11:   state_d = S_REST;
            2'b01:   state_d = S_UP_HELD;
            2'b10:   state_d = S_DN_HELD;
            default: state_d = S_PRESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_REST;
        else        state_q <= state_d;
    end

    always_comb begin
        cmd_o = CMD_NONE;
        unique case (state_q)
            S_REST: begin
                if (state_d == S_UP_HELD)      cmd_o = CMD_INC;
                else if (state_d == S_DN_HELD) cmd_o = CMD_DEC;
                else if (state_d == S_PRESET)  cmd_o = CMD_MID;
            end
            S_UP_HELD: begin
                if (state_d == S_DN_HELD)      cmd_o = CMD_DEC;
                else if (state_d == S_PRESET)  cmd_o = CMD_MID;
            end
            S_DN_HELD: begin
                if (state_d == S_UP_HELD)      cmd_o = CMD_INC;
                else if (state_d == S_PRESET)  cmd_o = CMD_MID;
            end
            S_PRESET: begin
                if (state_d == S_PRESET)       cmd_o = CMD_MID;
            end
        endcase
    end

    // R2: an increment is only ever followed by the raise-held state
    assert_inc_enters_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_INC) |=> (state_q == S_UP_HELD));
    // R3: a decrement is only ever followed by the lower-held state
    assert_dec_enters_dn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_DEC) |=> (state_q == S_DN_HELD));
    // R9: a held input never issues a second step
    assert_no_repeat_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_INC || cmd_o == CMD_DEC) |=> (cmd_o != $past(cmd_o)));
endmodule

// File: rtl/ccc_code_reg.sv
module ccc_code_reg
    import ccc_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  step_cmd_e         cmd_i,
    output logic [CODE_W-1:0] code_o,
    output logic              sat_o
);
    localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MIN = '0;

    logic [CODE_W-1:0] code_q;
    logic              sat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= CODE_MID;
            sat_q  <= 1'b0;
        end else begin
            sat_q <= 1'b0;
            if (en_i) begin
                unique case (cmd_i)
                    CMD_INC: begin
                        if (code_q == CODE_MAX) sat_q  <= 1'b1;
                        else                    code_q <= code_q + 1'b1;
                    end
                    CMD_DEC: begin
                        if (code_q == CODE_MIN) sat_q  <= 1'b1;
                        else                    code_q <= code_q - 1'b1;
                    end
                    CMD_MID:  code_q <= CODE_MID;
                    CMD_NONE: code_q <= code_q;
                endcase
            end
        end
    end

    assign code_o = code_q;
    assign sat_o  = sat_q;

    // R6/R7: a refused step leaves the code where it was
    assert_sat_holds_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sat_q |-> $stable(code_q));
    // R6/R7: the flag lasts one cycle
    assert_sat_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sat_q |=> !sat_q);
    // R8: power-down freezes code and flag
    assert_frozen_when_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(code_q) && !sat_q));
    // R9: any change is one count or the preset
    assert_single_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_q) |-> (code_q == CODE_W'($past(code_q) + 1'b1) ||
                              code_q == CODE_W'($past(code_q) - 1'b1) ||
                              code_q == CODE_MID));
endmodule

// File: rtl/contrast_code_ctrl.sv
module contrast_code_ctrl
    import ccc_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn_n,
    input  logic              step_up_n,
    input  logic              step_dn_n,
    output logic [CODE_W-1:0] code,
    output logic              sat
);
    logic [1:0] lvl_n;
    step_cmd_e  cmd;

    ccc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({step_up_n, step_dn_n}),
        .sync_o  (lvl_n)
    );

    ccc_step_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_lvl_n (lvl_n[1]),
        .dn_lvl_n (lvl_n[0]),
        .cmd_o    (cmd)
    );

    ccc_code_reg #(.CODE_W(CODE_W)) u_code (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (pwr_dn_n),
        .cmd_i  (cmd),
        .code_o (code),
        .sat_o  (sat)
    );

    // R4: both synchronized inputs low with power on gives midscale next cycle
    assert_both_low_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_n == 2'b00 && pwr_dn_n) |=> (code == {1'b1, {(CODE_W-1){1'b0}}}));
endmodule

// File: tb/tb_contrast_code_ctrl.sv
module tb_contrast_code_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_dn_n = 1'b1;
    logic       step_up_n = 1'b1;
    logic       step_dn_n = 1'b1;
    logic [5:0] code;
    logic       sat;
    int         errors = 0;
    int         checks = 0;
    int         exp_code = 32;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    contrast_code_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n),
        .step_up_n(step_up_n), .step_dn_n(step_dn_n),
        .code(code), .sat(sat)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // drive a level change at a negedge, sample after the third rising edge
    task automatic drive_and_settle(input logic up_v, input logic dn_v);
        @(negedge clk);
        step_up_n = up_v;
        step_dn_n = dn_v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one press and release of one input
    task automatic press(input bit is_up, input string req);
        int exp_sat;
        exp_sat = 0;
        if (is_up) begin
            if (exp_code == 63) exp_sat = 1; else exp_code++;
            drive_and_settle(1'b0, 1'b1);
        end else begin
            if (exp_code == 0) exp_sat = 1; else exp_code--;
            drive_and_settle(1'b1, 1'b0);
        end
        check(req, code, exp_code);
        check(req, sat, exp_sat);
        @(negedge clk);
        check({req, " sat one cycle"}, sat, 0);
        step_up_n = 1'b1;
        step_dn_n = 1'b1;
        idle(4);
        check({req, " release no step R9"}, code, exp_code);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        idle(3);
        check("R1 reset code", code, 32);
        check("R1 reset sat", sat, 0);
        @(negedge clk) rst_n = 1'b1;
        idle(3);
        check("R1 after reset code", code, 32);
        check("R1 after reset sat", sat, 0);

        // upward sweep to the top, then one refused step
        for (int i = 0; i < 32; i++) press(1'b1, (i < 31) ? "R2 up" : "R6 up at max");
        check("R6 held at 63", code, 63);
        // downward sweep to the bottom, then one refused step
        for (int i = 0; i < 64; i++) press(1'b0, (i < 63) ? "R3 down" : "R7 down at min");
        check("R7 held at 0", code, 0);

        // R9: hold raise low a long time: one step only
        drive_and_settle(1'b0, 1'b1);
        exp_code = 1;
        idle(10);
        check("R9 held low single step", code, exp_code);
        drive_and_settle(1'b1, 1'b1);
        check("R9 rising edge no step", code, exp_code);

        // R5: both fall in the same cycle from code 1
        drive_and_settle(1'b0, 1'b0);
        exp_code = 32;
        check("R5 simultaneous fall preset", code, 32);
        drive_and_settle(1'b1, 1'b1);
        check("R5 release after preset", code, 32);

        // move away from midscale, then preset via staggered press
        for (int i = 0; i < 5; i++) press(1'b1, "R2 up");
        check("R2 staging value", code, 37);
        drive_and_settle(1'b0, 1'b1);
        exp_code = 38;
        check("R2 staged raise", code, 38);
        drive_and_settle(1'b0, 1'b0);
        exp_code = 32;
        check("R4 both low preset", code, 32);
        drive_and_settle(1'b0, 1'b1);
        check("R4 release lower keeps preset", code, 32);
        drive_and_settle(1'b1, 1'b1);
        check("R4 release raise keeps preset", code, 32);
        press(1'b0, "R3 down");
        press(1'b0, "R3 down");

        // R8: power-down freezes everything
        @(negedge clk) pwr_dn_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            drive_and_settle(1'b0, 1'b1);
            check("R8 frozen code", code, exp_code);
            check("R8 frozen sat", sat, 0);
            drive_and_settle(1'b1, 1'b1);
        end
        drive_and_settle(1'b1, 1'b0);
        check("R8 frozen on lower", code, exp_code);
        drive_and_settle(1'b0, 1'b0);
        check("R8 frozen on both low", code, exp_code);
        drive_and_settle(1'b1, 1'b1);
        @(negedge clk) pwr_dn_n = 1'b1;
        idle(5);
        check("R8 no stale edges after wake", code, exp_code);
        press(1'b1, "R8 works after wake R2");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule